// File: doc/BRIEF.md
# SPI Flash Command Engine

This block runs short transactions with a serial flash from three 32-bit registers on a simple read/write bus. Software puts an opcode byte, a three-bit capture code and a select-hold flag in the control word, then writes it again with the start bit set. The engine lowers chip select and sends the opcode. If the capture code needs more bytes, it sends the low 24 address bits, most significant byte first, and then zero filler bytes. It stores the chosen received byte, or group of four bytes, in the data register. It then raises chip select and drops busy.

With the hold flag set, each start sends only the opcode byte and leaves chip select low afterwards. Software can then push a command and its payload one byte at a time and read each answer byte. The next start with the flag cleared ends the held sequence. The serial clock is a fixed division of the system clock, and all transfers use SPI mode 0.

Top module: `spi_cmd_engine`

## Requirements
- R1: After reset the control, address and data registers read 0, chip select is high and SCK is low. The control word is at byte offset 0x0, the address at 0x4 and the captured data at 0x8. Any other offset reads 0.
- R2: The control word holds the opcode in [7:0], the capture code in [10:8] and the hold flag in [12]. These fields read back as written. Bit 31 starts a transaction when written as 1 and reads 1 while the transaction runs. All other bits read 0.
- R3: A transaction without hold clocks a fixed number of bytes for each code: 1 for code 0, 2 for code 1, 4 for code 2, 5 for code 3, 8 for code 4, 12 for code 5, 3 for code 6 and 9 for code 7. Chip select goes high once the last byte is done.
- R4: Transmitted byte 1 is the opcode. Bytes 2, 3 and 4 are address bits [23:16], [15:8] and [7:0]. Every later byte is 0x00. Bits go out MSB first.
- R5: Codes 0, 1, 6, 2 and 3 store received byte 1, 2, 3, 4 and 5 respectively. The byte is zero-extended into data bits [7:0].
- R6: Codes 4, 7 and 5 store four consecutive received bytes, starting at byte 5, 6 and 9 respectively. The earliest byte lands in data [7:0] and the latest in [31:24].
- R7: A start with the hold flag set sends just the opcode byte and stores the byte received into data [7:0]. Busy then clears while chip select stays low. Chip select rises only at the end of a later start whose flag is cleared.
- R8: A control write arriving while busy is 1 changes nothing and starts nothing. A control write with bit 31 at 0 updates the fields without starting a transfer.
- R9: SCK is low whenever chip select is high. Each SCK half period lasts HALF_DIV system clocks, and MOSI does not change while SCK is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| spi_sck | output | 1 | Serial clock, idles low |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |
| spi_cs_n | output | 1 | Active-low chip select |

## Verification
The checker assumes that bus writes are single-cycle strobes with a stable offset. It also assumes that MISO is driven by a device that changes it only while SCK is low. The bench drives every bus access on the falling system clock edge for exactly one cycle. Its flash model updates MISO from the SCK rising-edge count, after the engine has sampled the previous value. It polls busy through the control register instead of timing transfers by cycle count, so the stimulus never relies on bus cycles the checker does not model.

// File: rtl/spi_eng_pkg.sv
`timescale 1ns/1ps
package spi_eng_pkg;

   typedef logic [2:0] cap_code_t;

   // number of byte slots a non-held transfer clocks for a capture code
   function automatic logic [3:0] act_len(input cap_code_t c);
      case (c)
         3'd0:    act_len = 4'd1;
         3'd1:    act_len = 4'd2;
         3'd2:    act_len = 4'd4;
         3'd3:    act_len = 4'd5;
         3'd4:    act_len = 4'd8;
         3'd5:    act_len = 4'd12;
         3'd6:    act_len = 4'd3;
         default: act_len = 4'd9;
      endcase
   endfunction

   // first byte slot (1-based) that lands in the data register
   function automatic logic [3:0] act_first(input cap_code_t c);
      case (c)
         3'd0:    act_first = 4'd1;
         3'd1:    act_first = 4'd2;
         3'd2:    act_first = 4'd4;
         3'd3:    act_first = 4'd5;
         3'd4:    act_first = 4'd5;
         3'd5:    act_first = 4'd9;
         3'd6:    act_first = 4'd3;
         default: act_first = 4'd6;
      endcase
   endfunction

   function automatic logic act_is_quad(input cap_code_t c);
      act_is_quad = (c == 3'd4) || (c == 3'd5) || (c == 3'd7);
   endfunction

endpackage

// File: rtl/spi_eng_clkdiv.sv
`timescale 1ns/1ps
module spi_eng_clkdiv #(
   parameter int HALF_DIV = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   output logic tick
);
   generate
      if (HALF_DIV < 1) begin : g_bad_div
         $error("spi_eng_clkdiv: HALF_DIV must be at least 1");
      end

      if (HALF_DIV == 1) begin : g_direct
         assign tick = en;
      end else begin : g_count
         localparam int CW = $clog2(HALF_DIV);
         localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);
         logic [CW-1:0] cnt_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt_q <= '0;
            end else if (!en || cnt_q == LAST) begin
               cnt_q <= '0;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end

         assign tick = en && (cnt_q == LAST);
      end
   endgenerate
endmodule

// File: rtl/spi_eng_shifter.sv
`timescale 1ns/1ps
module spi_eng_shifter #(
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [BYTE_W-1:0] tx_byte,
   input  logic              tick,
   input  logic              miso,
   output logic              sck,
   output logic              mosi,
   output logic              active,
   output logic              done,
   output logic [BYTE_W-1:0] rx_byte
);
   localparam int BW = $clog2(BYTE_W);
   localparam logic [BW-1:0] LAST_BIT = BW'(BYTE_W - 1);

   logic [BYTE_W-1:0] tx_q, rx_q;
   logic [BW-1:0]     bit_q;
   logic              sck_q, act_q, done_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_q   <= '0;
         rx_q   <= '0;
         bit_q  <= '0;
         sck_q  <= 1'b0;
         act_q  <= 1'b0;
         done_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (!act_q) begin
            if (start) begin
               act_q <= 1'b1;
               tx_q  <= tx_byte;
               bit_q <= '0;
               sck_q <= 1'b0;
            end
         end else if (tick) begin
            if (!sck_q) begin
               // rising edge: sample
               sck_q <= 1'b1;
               rx_q  <= {rx_q[BYTE_W-2:0], miso};
            end else begin
               // falling edge: advance
               sck_q <= 1'b0;
               if (bit_q == LAST_BIT) begin
                  act_q  <= 1'b0;
                  done_q <= 1'b1;
               end else begin
                  bit_q <= bit_q + 1'b1;
                  tx_q  <= {tx_q[BYTE_W-2:0], 1'b0};
               end
            end
         end
      end
   end

   assign sck     = sck_q;
   assign mosi    = tx_q[BYTE_W-1];
   assign active  = act_q;
   assign done    = done_q;
   assign rx_byte = rx_q;
endmodule

// File: rtl/spi_eng_seq.sv
`timescale 1ns/1ps
module spi_eng_seq
   import spi_eng_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        go,
   input  logic [7:0]  go_opcode,
   input  cap_code_t   go_code,
   input  logic        go_hold,
   input  logic [23:0] go_addr,
   input  logic        byte_done,
   input  logic [7:0]  rx_byte,
   output logic        byte_start,
   output logic [7:0]  tx_byte,
   output logic        busy,
   output logic        cs_n,
   output logic [31:0] cap_data
);
   logic        busy_q, sel_q, launch_q, hold_l;
   logic [3:0]  slot_q, total_q;
   logic [7:0]  op_l;
   cap_code_t   code_l;
   logic [23:0] addr_l;
   logic [31:0] data_q;

   logic [3:0]  first_w;
   logic [4:0]  win_end;
   logic        in_win;
   logic [1:0]  lane;

   always_comb begin
      first_w = act_first(code_l);
      win_end = {1'b0, first_w} + 5'd4;
      in_win  = (slot_q >= first_w) && ({1'b0, slot_q} < win_end);
      lane    = 2'(slot_q - first_w);
   end

   always_comb begin
      case (slot_q)
         4'd1:    tx_byte = op_l;
         4'd2:    tx_byte = addr_l[23:16];
         4'd3:    tx_byte = addr_l[15:8];
         4'd4:    tx_byte = addr_l[7:0];
         default: tx_byte = 8'h00;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q   <= 1'b0;
         sel_q    <= 1'b0;
         launch_q <= 1'b0;
         hold_l   <= 1'b0;
         slot_q   <= 4'd0;
         total_q  <= 4'd0;
         op_l     <= '0;
         code_l   <= '0;
         addr_l   <= '0;
         data_q   <= '0;
      end else begin
         launch_q <= 1'b0;
         if (go && !busy_q) begin
            busy_q   <= 1'b1;
            sel_q    <= 1'b1;
            launch_q <= 1'b1;
            hold_l   <= go_hold;
            op_l     <= go_opcode;
            code_l   <= go_code;
            addr_l   <= go_addr;
            slot_q   <= 4'd1;
            total_q  <= go_hold ? 4'd1 : act_len(go_code);
         end else if (busy_q && byte_done) begin
            if (hold_l) begin
               data_q <= {24'h0, rx_byte};
            end else if (act_is_quad(code_l)) begin
               if (in_win) data_q[lane*8 +: 8] <= rx_byte;
            end else if (slot_q == first_w) begin
               data_q <= {24'h0, rx_byte};
            end

            if (slot_q == total_q) begin
               busy_q <= 1'b0;
               if (!hold_l) sel_q <= 1'b0;
            end else begin
               slot_q   <= slot_q + 1'b1;
               launch_q <= 1'b1;
            end
         end
      end
   end

   assign byte_start = launch_q;
   assign busy       = busy_q;
   assign cs_n       = !sel_q;
   assign cap_data   = data_q;
endmodule

// File: rtl/spi_cmd_engine.sv
`timescale 1ns/1ps
module spi_cmd_engine
   import spi_eng_pkg::*;
#(
   parameter int ADDR_W   = 4,
   parameter int HALF_DIV = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic              spi_sck,
   output logic              spi_mosi,
   input  logic              spi_miso,
   output logic              spi_cs_n
);
   localparam logic [ADDR_W-1:0] OFS_CTRL = ADDR_W'(4'h0);
   localparam logic [ADDR_W-1:0] OFS_ADDR = ADDR_W'(4'h4);
   localparam logic [ADDR_W-1:0] OFS_DATA = ADDR_W'(4'h8);
   localparam int START_BIT = 31;
   localparam int HOLD_BIT  = 12;

   generate
      if (ADDR_W < 4) begin : g_bad_addr
         $error("spi_cmd_engine: ADDR_W must be at least 4");
      end
   endgenerate

   logic [7:0]  opcode_q;
   cap_code_t   action_q;
   logic        hold_q;
   logic [31:0] addr_q;
   logic        busy_w, go_w, ctrl_wr;
   logic        tick_w, sh_active, sh_done, sh_start;
   logic [7:0]  sh_tx, sh_rx;
   logic [31:0] data_w;
   logic        unused_wbits;

   assign ctrl_wr      = bus_wr && (bus_addr == OFS_CTRL) && !busy_w;
   assign go_w         = ctrl_wr && bus_wdata[START_BIT];
   assign unused_wbits = ^{bus_wdata[30:13], bus_wdata[11]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         opcode_q <= '0;
         action_q <= '0;
         hold_q   <= 1'b0;
         addr_q   <= '0;
      end else begin
         if (ctrl_wr) begin
            opcode_q <= bus_wdata[7:0];
            action_q <= bus_wdata[10:8];
            hold_q   <= bus_wdata[HOLD_BIT];
         end
         if (bus_wr && bus_addr == OFS_ADDR) addr_q <= bus_wdata;
      end
   end

   always_comb begin
      case (bus_addr)
         OFS_CTRL: bus_rdata = {busy_w, 18'h0, hold_q, 1'b0, action_q, opcode_q};
         OFS_ADDR: bus_rdata = addr_q;
         OFS_DATA: bus_rdata = data_w;
         default:  bus_rdata = 32'h0;
      endcase
   end

   spi_eng_seq u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .go         (go_w),
      .go_opcode  (bus_wdata[7:0]),
      .go_code    (bus_wdata[10:8]),
      .go_hold    (bus_wdata[HOLD_BIT]),
      .go_addr    (addr_q[23:0]),
      .byte_done  (sh_done),
      .rx_byte    (sh_rx),
      .byte_start (sh_start),
      .tx_byte    (sh_tx),
      .busy       (busy_w),
      .cs_n       (spi_cs_n),
      .cap_data   (data_w)
   );

   spi_eng_clkdiv #(.HALF_DIV(HALF_DIV)) u_div (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (sh_active),
      .tick  (tick_w)
   );

   spi_eng_shifter #(.BYTE_W(8)) u_shift (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (sh_start),
      .tx_byte (sh_tx),
      .tick    (tick_w),
      .miso    (spi_miso),
      .sck     (spi_sck),
      .mosi    (spi_mosi),
      .active  (sh_active),
      .done    (sh_done),
      .rx_byte (sh_rx)
   );
endmodule

// File: rtl/spi_cmd_engine_chk.sv
`timescale 1ns/1ps
module spi_cmd_engine_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       spi_sck,
   input logic       spi_mosi,
   input logic       spi_cs_n,
   input logic       busy,
   input logic [7:0] opcode,
   input logic [2:0] action,
   input logic       hold
);
   // R9: no clock while deselected
   a_r9_sck_idle: assert property (@(posedge clk) disable iff (!rst_n)
      spi_cs_n |-> !spi_sck);

   // R9: data held through the high phase
   a_r9_mosi_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (spi_sck && $past(spi_sck)) |-> $stable(spi_mosi));

   // R2: a running transfer always has the flash selected
   a_r2_busy_selected: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !spi_cs_n);

   // R3: deselect only happens as the transfer ends
   a_r3_cs_release_idle: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(spi_cs_n) |-> !busy);

   // R8: control fields frozen while busy
   a_r8_fields_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> ($stable(opcode) && $stable(action) && $stable(hold)));
endmodule

bind spi_cmd_engine spi_cmd_engine_chk u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .spi_sck  (spi_sck),
   .spi_mosi (spi_mosi),
   .spi_cs_n (spi_cs_n),
   .busy     (busy_w),
   .opcode   (opcode_q),
   .action   (action_q),
   .hold     (hold_q)
);

// File: tb/spi_cmd_engine_tb.sv
`timescale 1ns/1ps
module spi_cmd_engine_tb;
   localparam int ADDR_W   = 4;
   localparam int HALF_DIV = 2;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              bus_wr = 1'b0;
   logic [ADDR_W-1:0] bus_addr = '0;
   logic [31:0]       bus_wdata = '0;
   logic [31:0]       bus_rdata;
   logic              spi_sck, spi_mosi, spi_miso, spi_cs_n;

   int n_tests = 0;
   int n_fail  = 0;
   bit finished = 0;

   always #5 clk = ~clk;

   spi_cmd_engine #(.ADDR_W(ADDR_W), .HALF_DIV(HALF_DIV)) u_dut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .spi_sck(spi_sck),
      .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_cs_n(spi_cs_n)
   );

   // ---------------- flash model ----------------
   function automatic logic [7:0] resp(input int j);
      return 8'((j * 29) + 90);
   endfunction

   int         stream_bits = 0;
   int         log_bits = 0;
   logic       log_clr = 1'b0;
   logic [7:0] mosi_log [0:15];
   time        t_rise = 0;
   time        high_ns = 0;

   always @(posedge spi_sck or posedge spi_cs_n) begin
      if (spi_cs_n) stream_bits <= 0;
      else          stream_bits <= stream_bits + 1;
   end

   always_comb begin
      logic [7:0] b;
      b = resp(stream_bits / 8);
      spi_miso = spi_cs_n ? 1'b0 : b[7 - (stream_bits % 8)];
   end

   always @(posedge spi_sck or posedge log_clr) begin
      if (log_clr) log_bits <= 0;
      else begin
         if (log_bits < 128)
            mosi_log[log_bits / 8] <= {mosi_log[log_bits / 8][6:0], spi_mosi};
         log_bits <= log_bits + 1;
      end
   end

   always @(posedge spi_sck) t_rise = $time;
   always @(negedge spi_sck) high_ns = $time - t_rise;

   // ---------------- helpers ----------------
   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
      end
   endtask

   task automatic bus_write(input logic [ADDR_W-1:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic bus_read(input logic [ADDR_W-1:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_addr = a;
      #1 d = bus_rdata;
   endtask

   task automatic wait_idle();
      logic [31:0] v;
      for (int i = 0; i < 5000; i++) begin
         bus_read(4'h0, v);
         if (!v[31]) break;
      end
   endtask

   function automatic logic [31:0] ctrl_word(input bit start, input bit hold,
                                             input logic [2:0] code, input logic [7:0] op);
      return {start, 18'h0, hold, 1'b0, code, op};
   endfunction

   function automatic int exp_len(input logic [2:0] c);
      case (c)
         3'd0: return 1;  3'd1: return 2;  3'd2: return 4;  3'd3: return 5;
         3'd4: return 8;  3'd5: return 12; 3'd6: return 3;  default: return 9;
      endcase
   endfunction

   task automatic clear_log();
      log_clr = 1'b1; #1; log_clr = 1'b0;
   endtask

   // ---------------- scenarios ----------------
   task automatic t_reset();
      logic [31:0] v;
      bus_read(4'h0, v); chk("R1", "ctrl after reset", v, 0);
      bus_read(4'h4, v); chk("R1", "addr after reset", v, 0);
      bus_read(4'h8, v); chk("R1", "data after reset", v, 0);
      bus_read(4'hC, v); chk("R1", "unmapped offset", v, 0);
      chk("R1", "cs_n after reset", {31'h0, spi_cs_n}, 1);
      chk("R9", "sck after reset", {31'h0, spi_sck}, 0);
   endtask

   task automatic t_action(input logic [2:0] code, input logic [7:0] op,
                           input logic [31:0] adr);
      logic [31:0] v, exp;
      int n, first;
      n = exp_len(code);
      clear_log();
      bus_write(4'h4, adr);
      bus_write(4'h0, ctrl_word(1, 0, code, op));
      wait_idle();
      bus_read(4'h8, v);
      case (code)
         3'd4: first = 4;
         3'd5: first = 8;
         3'd7: first = 5;
         default: first = 0;
      endcase
      if (first != 0) begin
         exp = {resp(first + 3), resp(first + 2), resp(first + 1), resp(first)};
         chk("R6", $sformatf("quad capture code %0d", code), v, exp);
      end else begin
         exp = {24'h0, resp(n - 1)};
         chk("R5", $sformatf("single capture code %0d", code), v, exp);
      end
      chk("R3", $sformatf("sck rises code %0d", code), 32'(log_bits), 32'(8 * n));
      chk("R3", "cs_n high after transfer", {31'h0, spi_cs_n}, 1);
      for (int k = 0; k < n; k++) begin
         case (k)
            0: exp = {24'h0, op};
            1: exp = {24'h0, adr[23:16]};
            2: exp = {24'h0, adr[15:8]};
            3: exp = {24'h0, adr[7:0]};
            default: exp = 0;
         endcase
         chk("R4", $sformatf("mosi byte %0d code %0d", k + 1, code),
             {24'h0, mosi_log[k]}, exp);
      end
      chk("R9", "sck high width ns", 32'(high_ns), 32'(HALF_DIV * 10));
   endtask

   task automatic t_fields_no_start();
      logic [31:0] v;
      clear_log();
      bus_write(4'h0, ctrl_word(0, 1, 3'd5, 8'hC3));
      repeat (20) @(negedge clk);
      bus_read(4'h0, v);
      chk("R2", "fields read back", v, ctrl_word(0, 1, 3'd5, 8'hC3));
      chk("R8", "no start without bit31 (cs_n)", {31'h0, spi_cs_n}, 1);
      chk("R8", "no clocks without bit31", 32'(log_bits), 0);
   endtask

   task automatic t_busy_ignore();
      logic [31:0] v;
      clear_log();
      bus_write(4'h4, 32'h00_12_34_56);
      bus_write(4'h0, ctrl_word(1, 0, 3'd5, 8'h0B));
      bus_read(4'h0, v);
      chk("R2", "busy while running", {31'h0, v[31]}, 1);
      bus_write(4'h0, ctrl_word(1, 0, 3'd0, 8'h77));
      wait_idle();
      bus_read(4'h0, v);
      chk("R8", "ctrl unchanged by busy write", v, ctrl_word(0, 0, 3'd5, 8'h0B));
      repeat (40) @(negedge clk);
      chk("R8", "no second transfer", 32'(log_bits), 96);
      chk("R8", "cs_n high after ignored write", {31'h0, spi_cs_n}, 1);
   endtask

   task automatic t_hold();
      logic [31:0] v;
      clear_log();
      bus_write(4'h4, 32'h00AB_CDEF);
      bus_write(4'h0, ctrl_word(1, 1, 3'd5, 8'h9F));
      wait_idle();
      bus_read(4'h8, v);
      chk("R7", "hold byte 1 data", v, {24'h0, resp(0)});
      chk("R7", "cs_n low after held byte", {31'h0, spi_cs_n}, 0);
      chk("R7", "held start sends one byte", 32'(log_bits), 8);
      chk("R7", "held byte is opcode", {24'h0, mosi_log[0]}, 32'h9F);
      bus_write(4'h0, ctrl_word(1, 1, 3'd0, 8'h5A));
      wait_idle();
      bus_read(4'h8, v);
      chk("R7", "hold byte 2 data", v, {24'h0, resp(1)});
      chk("R7", "cs_n still low", {31'h0, spi_cs_n}, 0);
      chk("R7", "second held byte tx", {24'h0, mosi_log[1]}, 32'h5A);
      bus_write(4'h0, ctrl_word(1, 0, 3'd0, 8'h33));
      wait_idle();
      bus_read(4'h8, v);
      chk("R7", "closing byte data", v, {24'h0, resp(2)});
      chk("R7", "cs_n released after unheld start", {31'h0, spi_cs_n}, 1);
      chk("R7", "total bytes in held sequence", 32'(log_bits), 24);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_action(3'd0, 8'h05, 32'h00_11_22_33);
      t_action(3'd1, 8'h9F, 32'h00_44_55_66);
      t_action(3'd6, 8'h90, 32'h00_A1_B2_C3);
      t_action(3'd2, 8'h03, 32'hFF_01_02_03);
      t_action(3'd3, 8'h0B, 32'h00_7E_81_18);
      t_action(3'd4, 8'h03, 32'h00_00_10_00);
      t_action(3'd7, 8'h0B, 32'h00_C0_FF_EE);
      t_action(3'd5, 8'h4B, 32'h00_12_00_34);
      t_fields_no_start();
      t_busy_ignore();
      t_hold();
      if (!finished) begin
         finished = 1;
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      #1_500_000;
      if (!finished) begin
         finished = 1;
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end
endmodule